// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a watchdog counter that advances only on a slow, independent tick, a single-cycle enable that comes from a low-frequency oscillator (nominally 31 kHz) and has already been synchronized into the system clock domain. A 2-bit configuration input and a software enable bit decide when the watchdog may count. The decision also depends on whether the device is asleep. A loadable 5-bit period select sets the time-out length. It ranges from 32 ticks (about 1 ms) up to 2^23 ticks (about 256 s).

Several system events restart the count from zero: a clear command, an oscillator failure, sleep entry, sleep exit, and the watchdog becoming disabled. The count is also held at zero for as long as the oscillator start-up timer reports that it is running. A time-out while awake raises a one-cycle reset request. A time-out while asleep raises a one-cycle wake request instead, and the block returns to the awake state. Two status flags record what happened: one for time-out and one for power-down. A power-on reset sets both flags.

Top module: `wdog_sleep`

## Requirements
- R1: After `rst_n` is released, `to_flag` and `pd_flag` are 1, and `rst_req`, `wake_req` and `asleep` are 0. The period select is 11, so the first time-out comes on the 65536th tick.
- R2: The counter advances only in cycles where `lf_tick` is 1. With period select PS (0 to 18), a time-out occurs on the 2^(5+PS)th counted tick after the last clear. Codes 19 to 31 give the same period as 18. `ps_load` = 1 copies `ps_sel` into the period select.
- R3: Counting is allowed as follows. With `cfg_mode` = 3 it always counts. With 2 it counts only while awake. With 1 it counts only while `sw_en` = 1, asleep or awake. With 0 it never counts.
- R4: The count restarts from zero after `clr_cmd`, `osc_fail`, `sleep_enter` or `sleep_exit`, or after any cycle in which counting is not allowed.
- R5: While `ost_run` = 1 the count is held at zero. It starts counting from zero once `ost_run` returns to 0.
- R6: A time-out while awake drives `rst_req` high for exactly one cycle, in the cycle that follows the clock edge that took the final tick. The same edge clears `to_flag` to 0.
- R7: A time-out while asleep drives `wake_req` for one cycle with the same timing, and `rst_req` stays low. It clears `to_flag` and returns `asleep` to 0.
- R8: `sleep_enter` sets `asleep` and clears `pd_flag` to 0. `sleep_exit` clears `asleep`. The flags return to 1 only through `rst_req`-independent power-on reset (`rst_n`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| lf_tick | input | 1 | Synchronized single-cycle tick of the low-frequency time base |
| cfg_mode | input | 2 | Enable mode: 3 always, 2 awake only, 1 software, 0 off |
| sw_en | input | 1 | Software enable, used in mode 1 |
| ps_load | input | 1 | Load strobe for the period select |
| ps_sel | input | 5 | New period select value |
| clr_cmd | input | 1 | Clear command strobe |
| sleep_enter | input | 1 | Sleep entry strobe |
| sleep_exit | input | 1 | Sleep exit strobe |
| osc_fail | input | 1 | Oscillator-fail event strobe |
| ost_run | input | 1 | Oscillator start-up timer running |
| rst_req | output | 1 | Reset request, one cycle, on time-out while awake |
| wake_req | output | 1 | Wake request, one cycle, on time-out while asleep |
| to_flag | output | 1 | Time-out status, 0 after a time-out |
| pd_flag | output | 1 | Power-down status, 0 after sleep entry |
| asleep | output | 1 | Current sleep state |

## Verification
Each fault in the count shows at the ports as a request pulse that lands on the wrong tick. A missed clear, a wrong enable decision or a wrong period all do this. The fault becomes visible at the latest one full period after it happens, as a pulse that is early, late or missing, so the bench compares every pulse against the tick index it predicted. If the sleep state is wrong, the wrong kind of request appears (reset instead of wake), or a request shows up in a mode that should be silent. A flag error is visible on the very next cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W   = 23;
  localparam int PS_W    = 5;
  localparam int PS_BASE = 5;
  localparam int PS_TOP  = 18;
  localparam int PS_RST  = 11;

  typedef enum logic [1:0] {
    WD_OFF     = 2'b00,
    WD_SOFT    = 2'b01,
    WD_NOSLEEP = 2'b10,
    WD_ON      = 2'b11
  } wd_mode_e;

  // Last count value before time-out: 2^(PS_BASE+ps) - 1, reserved codes saturate.
  function automatic logic [CNT_W-1:0] last_count(input logic [PS_W-1:0] ps);
    int eff;
    logic [CNT_W:0] one;
    logic [CNT_W:0] span;
    eff  = (int'(ps) > PS_TOP) ? PS_TOP : int'(ps);
    one  = {{CNT_W{1'b0}}, 1'b1};
    span = (one << (PS_BASE + eff)) - one;
    return span[CNT_W-1:0];
  endfunction

  function automatic logic run_allowed(input wd_mode_e m, input logic sw, input logic slp);
    logic ok;
    case (m)
      WD_ON:      ok = 1'b1;
      WD_NOSLEEP: ok = ~slp;
      WD_SOFT:    ok = sw;
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/wdog_gate.sv
module wdog_gate
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       sw_en,
  input  logic       clr_cmd,
  input  logic       sleep_enter,
  input  logic       sleep_exit,
  input  logic       wake_evt,
  input  logic       osc_fail,
  input  logic       ost_run,
  output logic       asleep,
  output logic       run_en,
  output logic       cnt_clr
);
  logic asleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       asleep_q <= 1'b0;
    else if (sleep_exit || wake_evt)  asleep_q <= 1'b0;
    else if (sleep_enter)             asleep_q <= 1'b1;
  end

  assign asleep  = asleep_q;
  assign run_en  = run_allowed(wd_mode_e'(cfg_mode), sw_en, asleep_q);
  assign cnt_clr = clr_cmd | osc_fail | sleep_enter | sleep_exit | ost_run | ~run_en;

  // R8: entry without a simultaneous exit leaves the block asleep
  a_r8_enter_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_enter && !sleep_exit && !wake_evt) |=> asleep);
  // R7: a wake event always leaves the block awake
  a_r7_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !asleep);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int PW  = PS_W
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_tick,
  input  logic          cnt_clr,
  input  logic          ps_load,
  input  logic [PW-1:0] ps_sel,
  output logic          tmo_evt
);
  logic [PW-1:0] ps_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= PW'(PS_RST);
    else if (ps_load) ps_q <= ps_sel;
  end

  assign cnt_last = last_count(ps_q);
  assign tmo_evt  = lf_tick & ~cnt_clr & (cnt_q >= cnt_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (lf_tick) cnt_q <= tmo_evt ? '0 : cnt_q + 1'b1;
  end

  // R4: any clear leaves the count at zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0));
  // R2: without a tick the count does not move
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!lf_tick && !cnt_clr) |=> $stable(cnt_q));
  // R5: time-out never fires while the start-up timer runs
  a_r5_no_tmo_clr: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |-> !tmo_evt);
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tmo_evt,
  input  logic asleep,
  input  logic sleep_enter,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag,
  output logic pd_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b1;
      pd_flag  <= 1'b1;
    end else begin
      rst_req  <= tmo_evt & ~asleep;
      wake_req <= tmo_evt & asleep;
      if (tmo_evt)     to_flag <= 1'b0;
      if (sleep_enter) pd_flag <= 1'b0;
    end
  end

  // R6: reset request is a single-cycle pulse
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7: wake and reset never together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));
  // R6: a request always comes with a cleared time-out flag
  a_r6_to_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> !to_flag);
  // R8: power-down flag only falls after sleep entry
  a_r8_pd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_flag) |-> $past(sleep_enter));
  // R8: flags never rise outside power-on reset
  a_r8_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(to_flag) && !$rose(pd_flag));
endmodule

// File: rtl/wdog_sleep.sv
module wdog_sleep
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lf_tick,
  input  logic [1:0]      cfg_mode,
  input  logic            sw_en,
  input  logic            ps_load,
  input  logic [PS_W-1:0] ps_sel,
  input  logic            clr_cmd,
  input  logic            sleep_enter,
  input  logic            sleep_exit,
  input  logic            osc_fail,
  input  logic            ost_run,
  output logic            rst_req,
  output logic            wake_req,
  output logic            to_flag,
  output logic            pd_flag,
  output logic            asleep
);
  logic run_en;
  logic cnt_clr;
  logic tmo_evt;
  logic wake_evt;

  assign wake_evt = tmo_evt & asleep;

  wdog_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .sw_en(sw_en),
    .clr_cmd(clr_cmd), .sleep_enter(sleep_enter), .sleep_exit(sleep_exit),
    .wake_evt(wake_evt), .osc_fail(osc_fail), .ost_run(ost_run),
    .asleep(asleep), .run_en(run_en), .cnt_clr(cnt_clr)
  );

  wdog_count #(.CW(CNT_W), .PW(PS_W)) u_count (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .cnt_clr(cnt_clr),
    .ps_load(ps_load), .ps_sel(ps_sel), .tmo_evt(tmo_evt)
  );

  wdog_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tmo_evt(tmo_evt), .asleep(asleep),
    .sleep_enter(sleep_enter), .rst_req(rst_req), .wake_req(wake_req),
    .to_flag(to_flag), .pd_flag(pd_flag)
  );

  // R3: a disabled watchdog raises no time-out
  a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !tmo_evt);
endmodule

// File: tb/wdog_sleep_bench.sv
module wdog_sleep_bench;
  localparam int CLK_NS = 10;

  typedef struct { int kind; int idx; string req; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lf_tick = 1'b0;
  logic [1:0] cfg_mode = 2'b11;
  logic sw_en = 1'b0;
  logic ps_load = 1'b0;
  logic [4:0] ps_sel = 5'd0;
  logic clr_cmd = 1'b0, sleep_enter = 1'b0, sleep_exit = 1'b0;
  logic osc_fail = 1'b0, ost_run = 1'b0;
  logic rst_req, wake_req, to_flag, pd_flag, asleep;

  int n_chk = 0;
  int n_fail = 0;
  int tick_idx = 0;
  exp_t exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  wdog_sleep u_wdog_sleep (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .cfg_mode(cfg_mode),
    .sw_en(sw_en), .ps_load(ps_load), .ps_sel(ps_sel), .clr_cmd(clr_cmd),
    .sleep_enter(sleep_enter), .sleep_exit(sleep_exit), .osc_fail(osc_fail),
    .ost_run(ost_run), .rst_req(rst_req), .wake_req(wake_req),
    .to_flag(to_flag), .pd_flag(pd_flag), .asleep(asleep)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Period in ticks for a select code, saturating above 18.
  function automatic int period(input int ps);
    return 1 << (5 + ((ps > 18) ? 18 : ps));
  endfunction

  // kind 0 = reset request, 1 = wake request
  task automatic expect_evt(input int kind, input int n, input string req);
    exp_t e;
    e.kind = kind; e.idx = tick_idx + n; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: every request pulse is matched against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && (rst_req || wake_req)) begin
      if (exp_q.size() == 0) begin
        chk("R3", "unexpected request pulse", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "request kind", wake_req ? 1 : 0, e.kind);
        chk(e.req, "request tick index", tick_idx, e.idx);
      end
    end
  end

  task automatic tk(input int n);
    repeat (n) begin
      @(negedge clk); lf_tick = 1'b1; tick_idx++;
      @(negedge clk); lf_tick = 1'b0;
    end
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: clr_cmd = 1'b1;
      1: osc_fail = 1'b1;
      2: sleep_enter = 1'b1;
      default: sleep_exit = 1'b1;
    endcase
    @(negedge clk);
    clr_cmd = 1'b0; osc_fail = 1'b0; sleep_enter = 1'b0; sleep_exit = 1'b0;
  endtask

  task automatic load_ps(input int v);
    @(negedge clk); ps_sel = 5'(v); ps_load = 1'b1;
    @(negedge clk); ps_load = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    @(negedge clk); cfg_mode = 2'(m);
  endtask

  initial begin
    #(CLK_NS * 190000);
    chk("WDG", "watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "to_flag", to_flag, 1);
    chk("R1", "pd_flag", pd_flag, 1);
    chk("R1", "asleep", asleep, 0);
    chk("R1", "rst_req", rst_req, 0);

    // R2/R6 shortest period, always-on mode
    load_ps(0);
    expect_evt(0, period(0), "R6");
    tk(period(0));
    chk("R6", "to_flag after awake time-out", to_flag, 0);
    load_ps(2);
    expect_evt(0, period(2), "R2");
    tk(period(2));
    load_ps(0);

    // R4 clear command and oscillator fail restart the count
    tk(20); strobe(0);
    expect_evt(0, 32, "R4"); tk(32);
    tk(25); strobe(1);
    expect_evt(0, 32, "R4"); tk(32);

    // R5 start-up timer holds the count clear
    tk(10);
    @(negedge clk); ost_run = 1'b1;
    tk(50);
    @(negedge clk); ost_run = 1'b0;
    expect_evt(0, 32, "R5"); tk(32);

    // R3 enable modes
    set_mode(0); tk(100);
    set_mode(1); sw_en = 1'b0; tk(100);
    @(negedge clk); sw_en = 1'b1;
    expect_evt(0, 32, "R3"); tk(32);
    set_mode(3); tk(20);
    set_mode(0); set_mode(3);
    expect_evt(0, 32, "R4"); tk(32);

    // R7/R8 sleep in always-on mode wakes
    tk(20);
    strobe(2);
    chk("R8", "pd_flag after sleep entry", pd_flag, 0);
    chk("R8", "asleep after sleep entry", asleep, 1);
    expect_evt(1, 32, "R7"); tk(32);
    chk("R7", "asleep after wake", asleep, 0);

    // R3 awake-only mode is silent in sleep
    set_mode(2);
    strobe(2); tk(100);
    strobe(3);
    chk("R8", "asleep after sleep exit", asleep, 0);
    expect_evt(0, 32, "R3"); tk(32);

    // R3 software mode keeps running in sleep
    set_mode(1);
    strobe(2);
    expect_evt(1, 32, "R7"); tk(32);
    // R4 sleep exit restarts the count
    strobe(2); tk(20); strobe(3);
    expect_evt(0, 32, "R4"); tk(32);

    // R2 reserved code saturates to the longest period
    set_mode(3); load_ps(31); tk(4096);

    // R7 to_flag cleared by a sleep time-out
    do_reset();
    chk("R1", "to_flag after second reset", to_flag, 1);
    load_ps(0); strobe(2);
    expect_evt(1, 32, "R7"); tk(32);
    chk("R7", "to_flag after sleep time-out", to_flag, 0);
    chk("R7", "pd_flag stays low", pd_flag, 0);

    // R1 default period after reset
    do_reset();
    chk("R1", "pd_flag after reset", pd_flag, 1);
    expect_evt(0, period(11), "R1"); tk(period(11));

    repeat (3) @(negedge clk);
    chk("R2", "pending expected pulses", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule